// File: doc/BRIEF.md
# Translation Table Update Engine

This block keeps a table of translation entries for one I/O address window and carries out the maintenance commands that software issues against it. Each entry is 64 bits wide. Bits [1:0] hold the access permission, and the bits above the page offset hold the translated page address. The window has a base offset, a page size and an entry count, all fixed by parameters. The table answers to a single 32-bit identifier.

There are four commands. A single write stores one entry and a single read returns one. A fill writes one value into a run of consecutive pages. A list write fetches entries one at a time from system memory, through a read-request port, and stores each fetched entry into the next page. Every entry stored raises a one-cycle notification that carries the page-aligned window address, the masked translated address and the permission. Listeners can use it to drop stale cached translations.

A command is taken in any cycle where `cmd_valid` is high and the engine is not busy. It completes with a one-cycle `done` pulse and a status code.

Top module: `ttue_top`

## Requirements
- R1: A command whose identifier has a nonzero upper word, or whose lower word differs from `TABLE_ID`, completes with status 1 (parameter error). It writes nothing and raises no notification.
- R2: The I/O address is first rounded down to a page boundary. The page index is (rounded address − `BASE_OFS`) >> `PAGE_SHIFT`, taken as unsigned 64-bit. An index of `ENTRIES` or more fails with status 1 and leaves the table unchanged. An address below the base therefore fails.
- R3: Opcode 0 (single write) stores `cmd_val` at the indexed entry. It reports status 0 with `done` in the cycle after acceptance.
- R4: Opcode 1 (single read) returns the stored entry on `result` with status 0 and `done` in the cycle after acceptance. A failed read leaves `result` unchanged.
- R5: Opcode 2 (fill) is rejected at once with status 1 when the count is 0 or above `ENTRIES`. Otherwise it writes `cmd_val` to `count` consecutive pages, one page per cycle, and reports `done` one cycle after the last write.
- R6: Opcode 3 (list write) is rejected at once with status 1 when the count is 0, the count exceeds `LIST_MAX` (512), or the list address (`cmd_val`) has any of its low 12 bits set.
  - Entry i is fetched from address list+8·i. At most one request is outstanding at a time.
  - The fetched data is big-endian: the byte at the lowest address sits in `mem_rdata[7:0]` and is the most significant byte of the entry.
  - The entry is written in the cycle after its data arrives.
- R7: A fill or list write stops at the first page whose index is out of range and then reports status 1. Entries already written stay written.
- R8: Each entry write produces `ntf_valid` together with three values:
  - `ntf_iova` = page-aligned (address − base);
  - `ntf_xaddr` = entry with the page-offset bits cleared;
  - `ntf_perm` = entry[1:0], where 0 means no access, 1 read only, 2 write only and 3 read/write.
- R9: `busy` is high from the cycle after a fill or list write is accepted until its `done`. While `busy` is high, incoming commands are ignored.
- R10: Reset clears every entry to zero and leaves `busy`, `done`, `mem_req` and `ntf_valid` low with status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 write, 1 read, 2 fill, 3 list write |
| cmd_id | input | 64 | Table identifier |
| cmd_ioba | input | 64 | I/O bus address |
| cmd_val | input | 64 | Entry value, or list address for opcode 3 |
| cmd_cnt | input | CNT_W | Page count for batched commands |
| busy | output | 1 | Batched command in progress |
| done | output | 1 | Command completion pulse |
| status | output | 2 | 0 success, 1 parameter error |
| result | output | 64 | Entry returned by a read |
| mem_req | output | 1 | One-cycle fetch request |
| mem_addr | output | 64 | Fetch address |
| mem_rvalid | input | 1 | Fetch data valid |
| mem_rdata | input | 64 | Fetch data, lowest-address byte in bits [7:0] |
| ntf_valid | output | 1 | Entry-change notification |
| ntf_iova | output | 64 | Page-aligned window offset of the change |
| ntf_xaddr | output | 64 | Masked translated address |
| ntf_perm | output | 2 | Decoded permission |

## Verification
Single writes and reads, and every command rejected up front, give `done` exactly one cycle after acceptance. A fill that writes n pages gives `done` n+1 cycles after acceptance, or n+2 cycles when it stops on a bad page. List writes are paced by the memory latency, so the bench waits for `done` with a bound rather than an exact count. Inputs are driven on falling edges and outputs are sampled on the falling edge after each rising edge. Notifications are collected cycle by cycle while the bench waits for `done`. At the end the bench compares the count and the contents of the notifications with those predicted by its table model.

// File: rtl/ttue_pkg.sv
`timescale 1ns/1ps
package ttue_pkg;

    typedef enum logic [1:0] {
        OP_PUT  = 2'd0,
        OP_GET  = 2'd1,
        OP_FILL = 2'd2,
        OP_LIST = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_BADPARAM = 2'd1
    } status_e;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RD   = 2'd1,
        PERM_WR   = 2'd2,
        PERM_RW   = 2'd3
    } perm_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FILL  = 2'd1,
        S_FETCH = 2'd2,
        S_LWR   = 2'd3
    } eng_state_e;

    // Lowest-address byte sits in bits [7:0]; it becomes the most significant byte.
    function automatic logic [63:0] bswap64(input logic [63:0] v);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) begin
            r[8*b +: 8] = v[8*(7-b) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/ttue_precheck.sv
`timescale 1ns/1ps
module ttue_precheck
    import ttue_pkg::*;
#(
    parameter int          ENTRIES    = 16,
    parameter int          CNT_W      = 16,
    parameter int          LIST_MAX   = 512,
    parameter int          LIST_ALIGN = 12,
    parameter logic [31:0] TABLE_ID   = 32'h8000_0002
) (
    input  op_e                   op,
    input  logic [63:0]           id,
    input  logic [CNT_W-1:0]      cnt,
    input  logic [LIST_ALIGN-1:0] list_lo,
    output logic                  reject
);
    logic id_bad, fill_bad, list_bad, cnt_zero;

    always_comb begin
        id_bad   = (id[63:32] != 32'd0) || (id[31:0] != TABLE_ID);
        cnt_zero = (cnt == '0);
        fill_bad = (op == OP_FILL) && (cnt_zero || (cnt > CNT_W'(ENTRIES)));
        list_bad = (op == OP_LIST) &&
                   (cnt_zero || (cnt > CNT_W'(LIST_MAX)) || (list_lo != '0));
        reject   = id_bad || fill_bad || list_bad;
    end
endmodule

// File: rtl/ttue_index.sv
`timescale 1ns/1ps
module ttue_index #(
    parameter int          ENTRIES    = 16,
    parameter int          PAGE_SHIFT = 12,
    parameter logic [63:0] BASE_OFS   = 64'h0000_0000_0001_0000,
    localparam int         IW         = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [63:0]   addr,
    output logic [IW-1:0] idx,
    output logic          in_rng,
    output logic [63:0]   iova
);
    localparam logic [63:0] PMASK = ~((64'd1 << PAGE_SHIFT) - 64'd1);

    logic [63:0] rel_addr, rel_page;

    always_comb begin
        rel_addr = addr - BASE_OFS;
        rel_page = rel_addr >> PAGE_SHIFT;
        in_rng   = rel_page < 64'(ENTRIES);
        idx      = rel_page[IW-1:0];
        iova     = rel_addr & PMASK;
    end
endmodule

// File: rtl/ttue_store.sv
`timescale 1ns/1ps
module ttue_store #(
    parameter int  ENTRIES = 16,
    localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [63:0]   wdata,
    input  logic [IW-1:0] ridx,
    output logic [63:0]   rdata
);
    logic [63:0] ent_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
        end else if (we) begin
            ent_q[widx] <= wdata;
        end
    end

    assign rdata = ent_q[ridx];
endmodule

// File: rtl/ttue_top.sv
`timescale 1ns/1ps
module ttue_top
    import ttue_pkg::*;
#(
    parameter int          ENTRIES    = 16,
    parameter int          PAGE_SHIFT = 12,
    parameter int          CNT_W      = 16,
    parameter int          LIST_MAX   = 512,
    parameter int          LIST_ALIGN = 12,
    parameter logic [63:0] BASE_OFS   = 64'h0000_0000_0001_0000,
    parameter logic [31:0] TABLE_ID   = 32'h8000_0002
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [63:0]      cmd_id,
    input  logic [63:0]      cmd_ioba,
    input  logic [63:0]      cmd_val,
    input  logic [CNT_W-1:0] cmd_cnt,
    output logic             busy,
    output logic             done,
    output logic [1:0]       status,
    output logic [63:0]      result,
    output logic             mem_req,
    output logic [63:0]      mem_addr,
    input  logic             mem_rvalid,
    input  logic [63:0]      mem_rdata,
    output logic             ntf_valid,
    output logic [63:0]      ntf_iova,
    output logic [63:0]      ntf_xaddr,
    output logic [1:0]       ntf_perm
);
    localparam int          IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [63:0] PG    = 64'd1 << PAGE_SHIFT;
    localparam logic [63:0] PMASK = ~(PG - 64'd1);

    eng_state_e       st_q;
    logic [63:0]      cur_q, val_q, lptr_q, res_q;
    logic [CNT_W-1:0] rem_q;
    logic             done_q, mreq_q, nv_q;
    status_e          stat_q;
    logic [63:0]      niova_q, nxa_q;
    perm_e            nperm_q;

    op_e         op;
    logic        accept, reject, in_rng, wr_en;
    logic [63:0] sel_addr, iova, wr_data, rd_data;
    logic [IW-1:0] idx;

    assign op       = op_e'(cmd_op);
    assign accept   = cmd_valid && (st_q == S_IDLE);
    assign sel_addr = (st_q == S_IDLE) ? (cmd_ioba & PMASK) : cur_q;

    ttue_precheck #(
        .ENTRIES(ENTRIES), .CNT_W(CNT_W), .LIST_MAX(LIST_MAX),
        .LIST_ALIGN(LIST_ALIGN), .TABLE_ID(TABLE_ID)
    ) u_chk (
        .op(op), .id(cmd_id), .cnt(cmd_cnt),
        .list_lo(cmd_val[LIST_ALIGN-1:0]), .reject(reject)
    );

    ttue_index #(
        .ENTRIES(ENTRIES), .PAGE_SHIFT(PAGE_SHIFT), .BASE_OFS(BASE_OFS)
    ) u_idx (
        .addr(sel_addr), .idx(idx), .in_rng(in_rng), .iova(iova)
    );

    ttue_store #(.ENTRIES(ENTRIES)) u_tbl (
        .clk(clk), .rst(rst), .we(wr_en), .widx(idx), .wdata(wr_data),
        .ridx(idx), .rdata(rd_data)
    );

    always_comb begin
        wr_en   = 1'b0;
        wr_data = val_q;
        unique case (st_q)
            S_IDLE: begin
                if (accept && !reject && op == OP_PUT && in_rng) begin
                    wr_en   = 1'b1;
                    wr_data = cmd_val;
                end
            end
            S_FILL, S_LWR: wr_en = in_rng;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            cur_q   <= '0;
            val_q   <= '0;
            lptr_q  <= '0;
            res_q   <= '0;
            rem_q   <= '0;
            done_q  <= 1'b0;
            mreq_q  <= 1'b0;
            nv_q    <= 1'b0;
            stat_q  <= ST_OK;
            niova_q <= '0;
            nxa_q   <= '0;
            nperm_q <= PERM_NONE;
        end else begin
            done_q <= 1'b0;
            mreq_q <= 1'b0;
            nv_q   <= wr_en;
            if (wr_en) begin
                niova_q <= iova;
                nxa_q   <= wr_data & PMASK;
                nperm_q <= perm_e'(wr_data[1:0]);
            end
            unique case (st_q)
                S_IDLE: begin
                    if (accept) begin
                        cur_q  <= sel_addr;
                        val_q  <= cmd_val;
                        lptr_q <= cmd_val;
                        rem_q  <= cmd_cnt;
                        if (reject) begin
                            done_q <= 1'b1;
                            stat_q <= ST_BADPARAM;
                        end else begin
                            unique case (op)
                                OP_PUT: begin
                                    done_q <= 1'b1;
                                    stat_q <= in_rng ? ST_OK : ST_BADPARAM;
                                end
                                OP_GET: begin
                                    done_q <= 1'b1;
                                    stat_q <= in_rng ? ST_OK : ST_BADPARAM;
                                    if (in_rng) res_q <= rd_data;
                                end
                                OP_FILL: st_q <= S_FILL;
                                OP_LIST: begin
                                    st_q   <= S_FETCH;
                                    mreq_q <= 1'b1;
                                end
                            endcase
                        end
                    end
                end
                S_FILL, S_LWR: begin
                    if (!in_rng) begin
                        done_q <= 1'b1;
                        stat_q <= ST_BADPARAM;
                        st_q   <= S_IDLE;
                    end else if (rem_q == CNT_W'(1)) begin
                        done_q <= 1'b1;
                        stat_q <= ST_OK;
                        st_q   <= S_IDLE;
                    end else begin
                        rem_q <= rem_q - CNT_W'(1);
                        cur_q <= cur_q + PG;
                        if (st_q == S_LWR) begin
                            lptr_q <= lptr_q + 64'd8;
                            mreq_q <= 1'b1;
                            st_q   <= S_FETCH;
                        end
                    end
                end
                S_FETCH: begin
                    if (mem_rvalid) begin
                        val_q <= bswap64(mem_rdata);
                        st_q  <= S_LWR;
                    end
                end
            endcase
        end
    end

    assign busy      = (st_q != S_IDLE);
    assign done      = done_q;
    assign status    = stat_q;
    assign result    = res_q;
    assign mem_req   = mreq_q;
    assign mem_addr  = lptr_q;
    assign ntf_valid = nv_q;
    assign ntf_iova  = niova_q;
    assign ntf_xaddr = nxa_q;
    assign ntf_perm  = nperm_q;

    // R6: a fetch request only appears while waiting for list data
    assert_req_in_fetch_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (st_q == S_FETCH));

    // R6: never two requests back to back (one outstanding)
    assert_one_fetch_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R9: busy can only end with a completion pulse
    assert_busy_end_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R9: a completion after a batched run leaves the engine idle
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (done && $past(busy)) |-> !busy);

    // R5: a batched run in progress always has pages left to process
    assert_rem_live_R5: assert property (@(posedge clk) disable iff (rst)
        ((st_q == S_FILL) || (st_q == S_LWR)) |-> (rem_q != '0));
endmodule

// File: tb/tb_ttue_top.sv
`timescale 1ns/1ps
module tb_ttue_top;
    localparam int          ENT  = 16;
    localparam int          SH   = 12;
    localparam logic [63:0] BASE = 64'h0000_0000_0001_0000;
    localparam logic [31:0] TID  = 32'h8000_0002;
    localparam logic [63:0] PG   = 64'd1 << SH;
    localparam logic [63:0] PM   = ~(PG - 64'd1);

    logic        clk, rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [63:0] cmd_id, cmd_ioba, cmd_val;
    logic [15:0] cmd_cnt;
    logic        busy, done, mem_req, mem_rvalid, ntf_valid;
    logic [1:0]  status, ntf_perm;
    logic [63:0] result, mem_addr, mem_rdata, ntf_iova, ntf_xaddr;

    ttue_top dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_id(cmd_id), .cmd_ioba(cmd_ioba), .cmd_val(cmd_val),
        .cmd_cnt(cmd_cnt), .busy(busy), .done(done), .status(status),
        .result(result), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .ntf_valid(ntf_valid), .ntf_iova(ntf_iova), .ntf_xaddr(ntf_xaddr),
        .ntf_perm(ntf_perm)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    logic [63:0] mdl [ENT];
    logic [63:0] x_iova [32];
    logic [63:0] x_xa   [32];
    logic [1:0]  x_pm   [32];
    int          x_n, x_lat;
    logic [1:0]  x_st;
    logic [63:0] x_res;

    function automatic logic [63:0] swap8(input logic [63:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24],
                v[39:32], v[47:40], v[55:48], v[63:56]};
    endfunction

    function automatic logic [63:0] mem_val(input logic [63:0] a);
        return {a[31:0] * 32'd3, a[27:0], a[7:4]};
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_ntf(input logic [63:0] a, input logic [63:0] v);
        x_iova[x_n] = (a - BASE) & PM;
        x_xa[x_n]   = v & PM;
        x_pm[x_n]   = v[1:0];
        x_n++;
    endtask

    task automatic model(input logic [1:0] op, input logic [63:0] id,
                         input logic [63:0] ioba, input logic [63:0] val,
                         input logic [15:0] cnt);
        logic [63:0] a, rel, v;
        a = ioba & PM;
        x_n = 0; x_st = 2'd0; x_res = 64'd0; x_lat = 1;
        if (id[63:32] != 32'd0 || id[31:0] != TID) begin
            x_st = 2'd1;
        end else begin
            case (op)
                2'd0, 2'd1: begin
                    rel = (a - BASE) >> SH;
                    if (rel >= 64'(ENT)) x_st = 2'd1;
                    else if (op == 2'd0) begin mdl[rel] = val; push_ntf(a, val); end
                    else x_res = mdl[rel];
                end
                2'd2: begin
                    if (cnt == 0 || cnt > 16'(ENT)) x_st = 2'd1;
                    else begin
                        for (int i = 0; i < int'(cnt); i++) begin
                            rel = (a - BASE) >> SH;
                            if (rel >= 64'(ENT)) begin x_st = 2'd1; break; end
                            mdl[rel] = val; push_ntf(a, val); a = a + PG;
                        end
                        x_lat = x_n + ((x_st != 0) ? 2 : 1);
                    end
                end
                default: begin
                    if (cnt == 0 || cnt > 16'd512 || val[11:0] != 12'd0) x_st = 2'd1;
                    else begin
                        for (int i = 0; i < int'(cnt); i++) begin
                            rel = (a - BASE) >> SH;
                            if (rel >= 64'(ENT)) begin x_st = 2'd1; break; end
                            v = mem_val(val + 64'(8 * i));
                            mdl[rel] = v; push_ntf(a, v); a = a + PG;
                        end
                        x_lat = 0;
                    end
                end
            endcase
        end
    endtask

    task automatic run(input logic [1:0] op, input logic [63:0] id,
                       input logic [63:0] ioba, input logic [63:0] val,
                       input logic [15:0] cnt, input bit ign, input string tag);
        int cyc, o_n;
        bit fin;
        model(op, id, ioba, val, cnt);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_id = id;
        cmd_ioba = ioba; cmd_val = val; cmd_cnt = cnt;
        @(negedge clk);
        if (ign) begin
            // R9: a write to page 8 offered while busy must be dropped
            cmd_op = 2'd0; cmd_id = {32'd0, TID};
            cmd_ioba = BASE + 8 * PG; cmd_val = 64'hDEAD_BEEF_0000_0003;
        end else begin
            cmd_valid = 1'b0;
        end
        cyc = 1; o_n = 0; fin = 1'b0;
        while (!fin) begin
            if (cyc == 3) cmd_valid = 1'b0;
            if (cyc == 1 && op >= 2'd2 && x_lat != 1)
                chk(busy == 1'b1, {"R9 busy during batch ", tag}, 64'(busy), 64'd1);
            if (ntf_valid) begin
                if (o_n < x_n) begin
                    chk(ntf_iova == x_iova[o_n], {"R8 notify iova ", tag}, ntf_iova, x_iova[o_n]);
                    chk(ntf_xaddr == x_xa[o_n], {"R8 notify xaddr ", tag}, ntf_xaddr, x_xa[o_n]);
                    chk(ntf_perm == x_pm[o_n], {"R8 notify perm ", tag}, 64'(ntf_perm), 64'(x_pm[o_n]));
                end
                o_n++;
            end
            if (done) fin = 1'b1;
            else if (cyc > 400) begin
                chk(1'b0, {"R3 done timeout ", tag}, 64'(cyc), 64'd400);
                fin = 1'b1;
            end else begin
                cyc++;
                @(negedge clk);
            end
        end
        cmd_valid = 1'b0;
        chk(status == x_st, {"R1/R2 status ", tag}, 64'(status), 64'(x_st));
        if (op == 2'd1 && x_st == 2'd0)
            chk(result == x_res, {"R4 read data ", tag}, result, x_res);
        if (x_lat != 0)
            chk(cyc == x_lat, {"R5 latency ", tag}, 64'(cyc), 64'(x_lat));
        chk(o_n == x_n, {"R7 notify count ", tag}, 64'(o_n), 64'(x_n));
        chk(busy == 1'b0, {"R9 idle at done ", tag}, 64'(busy), 64'd0);
    endtask

    // Memory model: answers each request two cycles later with big-endian data
    initial begin
        int pend;
        logic [63:0] paddr;
        pend = 0; paddr = '0;
        mem_rvalid = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = swap8(mem_val(paddr));
                end
            end
            if (mem_req) begin
                pend  = 2;
                paddr = mem_addr;
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        chk(1'b0, "R9 watchdog expired", 64'd0, 64'd1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic do_reset();
        rst = 1'b1; cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < ENT; i++) mdl[i] = 64'd0;
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0 && mem_req == 1'b0 && ntf_valid == 1'b0,
            "R10 reset outputs", {busy, done, mem_req, ntf_valid}, 64'd0);
        chk(status == 2'd0, "R10 reset status", 64'(status), 64'd0);
    endtask

    initial begin
        logic [63:0] gid;
        void'($urandom(32'd20250611));
        gid = {32'd0, TID};
        cmd_op = '0; cmd_id = '0; cmd_ioba = '0; cmd_val = '0; cmd_cnt = '0;
        do_reset();

        run(2'd1, gid, BASE, 0, 0, 0, "R10 entry0 cleared");
        run(2'd0, {32'd1, TID}, BASE, 64'h1111_0003, 0, 0, "R1 upper id");
        run(2'd0, {32'd0, TID ^ 32'd1}, BASE, 64'h2222_0003, 0, 0, "R1 wrong id");
        run(2'd1, gid, BASE, 0, 0, 0, "R1 untouched");
        run(2'd0, gid, BASE + 3 * PG + 64'h123, 64'hABCD_5001, 0, 0, "R2 R3 unaligned write");
        run(2'd1, gid, BASE + 3 * PG + 64'hFFF, 0, 0, 0, "R4 read back");
        run(2'd0, gid, BASE - PG, 64'h77, 0, 0, "R2 below base");
        run(2'd0, gid, BASE + ENT * PG, 64'h77, 0, 0, "R2 index equals count");
        run(2'd1, gid, BASE + ENT * PG, 0, 0, 0, "R4 read out of range");
        run(2'd2, gid, BASE, 64'h5502, 17, 0, "R5 fill too many");
        run(2'd2, gid, BASE, 64'h5502, 0, 0, "R5 fill zero");
        run(2'd2, gid, BASE + 12 * PG, 64'h9000_0001, 6, 0, "R7 fill runs off end");
        run(2'd2, gid, BASE + PG, 64'h4400_0002, 5, 0, "R5 fill ok");
        run(2'd3, gid, BASE, 64'h2000_0100, 3, 0, "R6 list misaligned");
        run(2'd3, gid, BASE, 64'h2000_0000, 600, 0, "R6 list too long");
        run(2'd3, gid, BASE + 14 * PG, 64'h3000_0000, 4, 0, "R7 list runs off end");
        run(2'd3, gid, BASE, 64'h4000_0000, 5, 0, "R6 list ok");
        run(2'd2, gid, BASE, 64'h6600_0003, 4, 1, "R9 fill with ignored cmd");
        run(2'd1, gid, BASE + 8 * PG, 0, 0, 0, "R9 page 8 untouched");

        for (int k = 0; k < 60; k++) begin
            logic [1:0]  op;
            logic [63:0] id, ioba, val;
            logic [15:0] cnt;
            op   = 2'($urandom % 4);
            id   = ($urandom % 10 == 0) ? {32'd1, TID} :
                   (($urandom % 10 == 0) ? {32'd0, TID ^ 32'h10} : gid);
            ioba = BASE + 64'($urandom % 19) * PG + 64'($urandom % 4096);
            val  = {$urandom, $urandom};
            cnt  = 16'($urandom % 19);
            if (op == 2'd3) begin
                val = ($urandom % 8 == 0) ? 64'h5000_0040 : {32'd0, $urandom & 32'hFFFF_F000};
                cnt = 16'($urandom % 7);
            end
            run(op, id, ioba, val, cnt, 0, "R3 R5 R6 random");
        end

        for (int i = 0; i < ENT; i++)
            run(2'd1, gid, BASE + 64'(i) * PG, 0, 0, 0, "R4 final readback");

        do_reset();
        run(2'd1, gid, BASE + 3 * PG, 0, 0, 0, "R10 table cleared");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule